// File: doc/BRIEF.md
# Byte-Bus Management Message Target

This block is the controller-side end of a three-register byte channel that a host uses to send a request message to a management controller and to read its answer back. The host writes an operation into the control register and a byte into the data register. It then sets the busy bit in the flags register. The block acts on the operation in the next cycle: it takes or supplies one byte, writes a status code into the status register and clears busy in that same cycle.

Request bytes go into a request buffer. When the final byte arrives, the block raises a one-cycle pulse on a local port, and local logic reads the message out through a random-access port. Local logic fills a response buffer byte by byte and posts it with a length. The host then streams the response out one byte per handshake. Each phase ends with a result code left in the data register. A posted response can be flagged as unsolicited, and a flag bit then tells the host that such a message is waiting.

Top module: `smic_target`

## Requirements
- R1: After reset the status register reads 0xC0, the data register reads 0x00 and the flags register reads 0x40.
- R2: Host offsets are 0 for data, 1 for control (on write) or status (on read), and 2 for flags. Offset 3 reads 0x00. A control byte is accepted only when bits 7:5 equal 3'b010. Bits 3:0 then hold the operation: 0 get-status, 1 write-start, 2 write-next, 3 write-end, 4 read-start, 5 read-next, 6 read-end. Bit 4 is ignored. An accepted operation posts the status 0xC0 | operation.
- R3: A host write of the flags register with bit 0 set makes flags bit 0 (busy) read 1. On the next clock the status is posted and busy reads 0 in the same cycle. Host writes to any register while busy is 1 have no effect.
- R4: Write-start stores the data byte as request byte 0 and posts 0xC1. Each write-next appends the data byte and posts 0xC2. Write-end appends the last byte and posts 0xC3. The stored bytes can be read back in order through the request read port.
- R5: A write-end with no overflow leaves 0x00 in the data register. It raises the request-valid output for exactly one cycle, in the cycle the status is posted, with the request length on the length output.
- R6: Read-start presents response byte 0 with status 0xC4. Each read-next presents the next byte, with 0xC5 while bytes remain after it and 0xC6 for the final byte. Read-end posts 0xC0 with 0x00 in the data register and withdraws the response.
- R7: Flags bit 7 is 1 while a posted response has not been ended by read-end. Flags bit 6 is 1 when no phase is open, or when a write phase is open and the buffer holds fewer than MAX_BYTES bytes. Bits 5, 4, 3 and 1 read 0, so the flags never read 0xFF.
- R8: An illegal control byte gets status 0xC0 with error 0x02 in the data register and closes any open phase. This covers bad bits 7:5, an operation code above 6, write-next or write-end with no write phase open, read-next with no read phase open or no bytes left, and read-end with no read phase open.
- R9: A request of more than MAX_BYTES bytes keeps only the first MAX_BYTES bytes. Its write-end posts 0xC3 with error 0x05 in the data register and raises no request-valid.
- R10: Read-start when no response is posted gets status 0xC0 with error 0x03 in the data register.
- R11: A response posted as unsolicited sets flags bit 2. Bit 2 clears at the read-end of that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Host register offset |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Register contents at hostAddr (combinational) |
| rspWe | input | 1 | Local write of one response byte |
| rspAddr | input | AW | Response byte index |
| rspByte | input | 8 | Response byte value |
| rspPost | input | 1 | Make the loaded response available |
| rspLen | input | CW | Response length, 1 to MAX_BYTES |
| rspUnsol | input | 1 | Posted response is unsolicited |
| reqValid | output | 1 | One-cycle pulse: a complete request is stored |
| reqLen | output | CW | Number of stored request bytes |
| reqRdAddr | input | AW | Request buffer read index |
| reqRdData | output | 8 | Request byte at reqRdAddr |

## Verification
A three-byte request and a four-byte response show that the write statuses, the request ordering and the C5-versus-C6 choice on the last byte all depend on the byte count. The same four-byte response is then read once as a solicited answer and once as unsolicited, which separates the receive-ready bit from the message-waiting bit. An 81-byte request goes past the buffer edge: it shows when the transmit-ready bit drops and that buffer-full takes the place of request-valid. Single out-of-order operations and bad codes separate the illegal-control and no-response paths from normal flow. A data write attempted during busy must leave the byte that the block loaded.

// File: rtl/smic_pkg.sv
package smic_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_t;

  localparam logic [3:0] OP_GETST   = 4'd0;
  localparam logic [3:0] OP_WRSTART = 4'd1;
  localparam logic [3:0] OP_WRNEXT  = 4'd2;
  localparam logic [3:0] OP_WREND   = 4'd3;
  localparam logic [3:0] OP_RDSTART = 4'd4;
  localparam logic [3:0] OP_RDNEXT  = 4'd5;
  localparam logic [3:0] OP_RDEND   = 4'd6;

  localparam logic [2:0] CTRL_STREAM = 3'b010;
  localparam logic [3:0] STAT_PREFIX = 4'b1100;

  localparam logic [7:0] ERR_NONE   = 8'h00;
  localparam logic [7:0] ERR_ILLCTL = 8'h02;
  localparam logic [7:0] ERR_NORSP  = 8'h03;
  localparam logic [7:0] ERR_FULL   = 8'h05;

  typedef struct packed {
    logic       fire;
    logic [7:0] status;
    logic       ldErr;
    logic [7:0] errCode;
    logic       ldRsp;
    logic       rdRestart;
    logic       wrFirst;
    logic       wrAppend;
    logic       rdDone;
    logic       reqDone;
  } strobe_t;

endpackage

// File: rtl/smic_ctrl.sv
module smic_ctrl
  import smic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic [7:0] ctrlByte,
  input  logic       reqFull,
  input  logic       reqOvf,
  input  logic       rspAvail,
  input  logic       rdMore,
  input  logic       rdLast,
  output strobe_t    stb,
  output logic       txOpen
);

  phase_t phase, phaseNxt;
  logic   bad;
  logic   wrErr;

  assign wrErr  = reqOvf || reqFull;
  assign txOpen = (phase == PH_IDLE) || ((phase == PH_WRITE) && !reqFull);

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    bad      = 1'b0;
    if (busy) begin
      stb.fire   = 1'b1;
      stb.status = {STAT_PREFIX, ctrlByte[3:0]};
      if (ctrlByte[7:5] != CTRL_STREAM) begin
        bad = 1'b1;
      end else begin
        case (ctrlByte[3:0])
          OP_GETST: phaseNxt = PH_IDLE;
          OP_WRSTART: begin
            stb.wrFirst = 1'b1;
            phaseNxt    = PH_WRITE;
          end
          OP_WRNEXT: begin
            if (phase == PH_WRITE) stb.wrAppend = 1'b1;
            else bad = 1'b1;
          end
          OP_WREND: begin
            if (phase == PH_WRITE) begin
              stb.wrAppend = 1'b1;
              stb.ldErr    = 1'b1;
              stb.errCode  = wrErr ? ERR_FULL : ERR_NONE;
              stb.reqDone  = !wrErr;
              phaseNxt     = PH_IDLE;
            end else bad = 1'b1;
          end
          OP_RDSTART: begin
            if (rspAvail) begin
              stb.ldRsp     = 1'b1;
              stb.rdRestart = 1'b1;
              phaseNxt      = PH_READ;
            end else begin
              stb.status  = {STAT_PREFIX, OP_GETST};
              stb.ldErr   = 1'b1;
              stb.errCode = ERR_NORSP;
              phaseNxt    = PH_IDLE;
            end
          end
          OP_RDNEXT: begin
            if ((phase == PH_READ) && rdMore) begin
              stb.ldRsp  = 1'b1;
              stb.status = {STAT_PREFIX, rdLast ? OP_RDEND : OP_RDNEXT};
            end else bad = 1'b1;
          end
          OP_RDEND: begin
            if (phase == PH_READ) begin
              stb.status  = {STAT_PREFIX, OP_GETST};
              stb.ldErr   = 1'b1;
              stb.errCode = ERR_NONE;
              stb.rdDone  = 1'b1;
              phaseNxt    = PH_IDLE;
            end else bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      if (bad) begin
        stb         = '0;
        stb.fire    = 1'b1;
        stb.status  = {STAT_PREFIX, OP_GETST};
        stb.ldErr   = 1'b1;
        stb.errCode = ERR_ILLCTL;
        phaseNxt    = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

endmodule

// File: rtl/smic_dp.sv
module smic_dp
  import smic_pkg::*;
#(
  parameter  int MAX_BYTES = 80,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostAddr,
  input  logic          hostWr,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata,
  input  logic          rspWe,
  input  logic [AW-1:0] rspAddr,
  input  logic [7:0]    rspByte,
  input  logic          rspPost,
  input  logic [CW-1:0] rspLen,
  input  logic          rspUnsol,
  output logic          reqValid,
  output logic [CW-1:0] reqLen,
  input  logic [AW-1:0] reqRdAddr,
  output logic [7:0]    reqRdData,
  input  strobe_t       stb,
  input  logic          txOpen,
  output logic          busy,
  output logic [7:0]    ctrlByte,
  output logic [7:0]    statusReg,
  output logic [7:0]    dataReg,
  output logic          reqFull,
  output logic          reqOvf,
  output logic          rspAvail,
  output logic          rdMore,
  output logic          rdLast
);

  logic [7:0]    reqMem [MAX_BYTES];
  logic [7:0]    rspMem [MAX_BYTES];
  logic [CW-1:0] reqCnt, rdPos, rspLenR, rdIdx;
  logic          smsFlag;
  logic [7:0]    flags;

  assign reqFull   = (reqCnt == CW'(MAX_BYTES));
  assign rdMore    = (rdPos < rspLenR);
  assign rdLast    = ((rdPos + CW'(1)) == rspLenR);
  assign rdIdx     = stb.rdRestart ? '0 : rdPos;
  assign reqLen    = reqCnt;
  assign reqRdData = reqMem[reqRdAddr];
  assign flags     = {rspAvail, txOpen, 3'b000, smsFlag, 1'b0, busy};

  always_comb begin
    case (hostAddr)
      2'd0:    hostRdata = dataReg;
      2'd1:    hostRdata = statusReg;
      2'd2:    hostRdata = flags;
      default: hostRdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      ctrlByte  <= 8'h00;
      statusReg <= {STAT_PREFIX, OP_GETST};
      dataReg   <= ERR_NONE;
      reqCnt    <= '0;
      reqOvf    <= 1'b0;
      rdPos     <= '0;
      rspLenR   <= '0;
      rspAvail  <= 1'b0;
      smsFlag   <= 1'b0;
      reqValid  <= 1'b0;
    end else begin
      reqValid <= stb.reqDone;
      if (hostWr && !busy) begin
        case (hostAddr)
          2'd0:    dataReg  <= hostWdata;
          2'd1:    ctrlByte <= hostWdata;
          2'd2:    busy     <= hostWdata[0];
          default: ;
        endcase
      end
      if (stb.fire) begin
        busy      <= 1'b0;
        statusReg <= stb.status;
      end
      if (stb.ldErr) dataReg <= stb.errCode;
      if (stb.ldRsp) begin
        dataReg <= rspMem[rdIdx[AW-1:0]];
        rdPos   <= rdIdx + CW'(1);
      end
      if (stb.wrFirst) begin
        reqCnt <= CW'(1);
        reqOvf <= 1'b0;
      end else if (stb.wrAppend) begin
        if (reqFull) reqOvf <= 1'b1;
        else         reqCnt <= reqCnt + CW'(1);
      end
      if (rspPost) begin
        rspLenR  <= rspLen;
        rspAvail <= 1'b1;
        smsFlag  <= rspUnsol;
      end else if (stb.rdDone) begin
        rspAvail <= 1'b0;
        smsFlag  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrFirst)
      reqMem[0] <= dataReg;
    else if (stb.wrAppend && !reqFull)
      reqMem[reqCnt[AW-1:0]] <= dataReg;
  end

  always_ff @(posedge clk) begin
    if (rspWe) rspMem[rspAddr] <= rspByte;
  end

endmodule

// File: rtl/smic_target.sv
module smic_target
  import smic_pkg::*;
#(
  parameter  int MAX_BYTES = 80,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int AW = $clog2(MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostAddr,
  input  logic          hostWr,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata,
  input  logic          rspWe,
  input  logic [AW-1:0] rspAddr,
  input  logic [7:0]    rspByte,
  input  logic          rspPost,
  input  logic [CW-1:0] rspLen,
  input  logic          rspUnsol,
  output logic          reqValid,
  output logic [CW-1:0] reqLen,
  input  logic [AW-1:0] reqRdAddr,
  output logic [7:0]    reqRdData
);

  strobe_t    stb;
  logic       txOpen, busyW, reqFull, reqOvf, rspAvail, rdMore, rdLast;
  logic [7:0] ctrlByte, statusW, dataW;

  smic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busy(busyW), .ctrlByte(ctrlByte),
    .reqFull(reqFull), .reqOvf(reqOvf), .rspAvail(rspAvail),
    .rdMore(rdMore), .rdLast(rdLast), .stb(stb), .txOpen(txOpen)
  );

  smic_dp #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .rspWe(rspWe),
    .rspAddr(rspAddr), .rspByte(rspByte), .rspPost(rspPost),
    .rspLen(rspLen), .rspUnsol(rspUnsol), .reqValid(reqValid),
    .reqLen(reqLen), .reqRdAddr(reqRdAddr), .reqRdData(reqRdData),
    .stb(stb), .txOpen(txOpen), .busy(busyW), .ctrlByte(ctrlByte),
    .statusReg(statusW), .dataReg(dataW), .reqFull(reqFull),
    .reqOvf(reqOvf), .rspAvail(rspAvail), .rdMore(rdMore), .rdLast(rdLast)
  );

endmodule

// File: rtl/smic_target_chk.sv
module smic_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] hostAddr,
  input logic [7:0] hostRdata,
  input logic       busy,
  input logic [7:0] statusReg,
  input logic [7:0] dataReg,
  input logic       reqValid
);

  AST_FLAGS_NEVER_FF: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd2) |-> (hostRdata != 8'hFF)); // R7

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> !busy); // R3

  AST_STATUS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusReg) |-> $fell(busy)); // R3

  AST_REQ_WITH_END: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (statusReg == 8'hC3 && dataReg == 8'h00)); // R5

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R5

endmodule

bind smic_target smic_target_chk u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRdata(hostRdata),
  .busy(busyW), .statusReg(statusW), .dataReg(dataW), .reqValid(reqValid)
);

// File: tb/tb_smic_target.sv
module tb_smic_target;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 80;
  localparam int CW = $clog2(MAXB + 1);
  localparam int AW = $clog2(MAXB);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    hostAddr = 2'd0;
  logic          hostWr = 1'b0;
  logic [7:0]    hostWdata = 8'h00;
  logic [7:0]    hostRdata;
  logic          rspWe = 1'b0;
  logic [AW-1:0] rspAddr = '0;
  logic [7:0]    rspByte = 8'h00;
  logic          rspPost = 1'b0;
  logic [CW-1:0] rspLen = '0;
  logic          rspUnsol = 1'b0;
  logic          reqValid;
  logic [CW-1:0] reqLen;
  logic [AW-1:0] reqRdAddr = '0;
  logic [7:0]    reqRdData;

  smic_target #(.MAX_BYTES(MAXB)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .rspWe(rspWe),
    .rspAddr(rspAddr), .rspByte(rspByte), .rspPost(rspPost),
    .rspLen(rspLen), .rspUnsol(rspUnsol), .reqValid(reqValid),
    .reqLen(reqLen), .reqRdAddr(reqRdAddr), .reqRdData(reqRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural model
  int         mPhase = 0;
  logic [7:0] reqQ[$];
  logic [7:0] rspQ[$];
  bit         mOvf = 0;
  int         rdIdx = 0;
  bit         mAvail = 0;
  bit         mSms = 0;
  logic [7:0] mData = 8'h00;
  logic [7:0] mStatus = 8'hC0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mFlags();
    bit tx;
    tx = (mPhase == 0) || (mPhase == 1 && reqQ.size() < MAXB);
    return {mAvail, tx, 3'b000, mSms, 1'b0, 1'b0};
  endfunction

  task automatic modelCmd(input logic [7:0] c, input logic [7:0] d, output bit expReq);
    bit bad;
    logic [3:0] op;
    op = c[3:0];
    bad = 0;
    expReq = 0;
    mData = d;
    mStatus = {4'hC, op};
    if (c[7:5] != 3'b010 || op > 4'd6) bad = 1;
    else if (op == 0) mPhase = 0;
    else if (op == 1) begin reqQ = {d}; mOvf = 0; mPhase = 1; end
    else if (op == 2 || op == 3) begin
      if (mPhase != 1) bad = 1;
      else begin
        if (reqQ.size() < MAXB) reqQ.push_back(d); else mOvf = 1;
        if (op == 3) begin
          mData = mOvf ? 8'h05 : 8'h00;
          expReq = !mOvf;
          mPhase = 0;
        end
      end
    end else if (op == 4) begin
      if (!mAvail) begin mStatus = 8'hC0; mData = 8'h03; mPhase = 0; end
      else begin mData = rspQ[0]; rdIdx = 1; mPhase = 2; end
    end else if (op == 5) begin
      if (mPhase == 2 && rdIdx < rspQ.size()) begin
        mData = rspQ[rdIdx];
        mStatus = (rdIdx == rspQ.size() - 1) ? 8'hC6 : 8'hC5;
        rdIdx++;
      end else bad = 1;
    end else begin
      if (mPhase == 2) begin
        mStatus = 8'hC0; mData = 8'h00; mAvail = 0; mSms = 0; mPhase = 0;
      end else bad = 1;
    end
    if (bad) begin mStatus = 8'hC0; mData = 8'h02; mPhase = 0; end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    hostAddr = a; hostWdata = v; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    hostAddr = a;
    #1 v = hostRdata;
  endtask

  task automatic checkRegs(input string tag);
    logic [7:0] v;
    readReg(2'd0, v); chk({tag, " data"}, v, mData);
    readReg(2'd1, v); chk({tag, " status"}, v, mStatus);
    readReg(2'd2, v); chk({tag, " flags"}, v, mFlags());
    chk("R7 flags not FF", (v == 8'hFF), 0);
  endtask

  // one full handshake; poke tries a data write while busy
  task automatic cmd(input logic [7:0] c, input logic [7:0] d, input string tag, input bit poke = 0);
    logic [7:0] v;
    bit expReq;
    hostWrite(2'd0, d);
    hostWrite(2'd1, c);
    @(negedge clk);
    hostAddr = 2'd2; hostWdata = 8'h01; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    readReg(2'd2, v);
    chk("R3 busy visible", v[0], 1'b1);
    if (poke) begin hostAddr = 2'd0; hostWdata = 8'hAA; hostWr = 1'b1; end
    @(negedge clk);
    hostWr = 1'b0;
    modelCmd(c, d, expReq);
    checkRegs(tag);
    chk({tag, " R5 reqValid"}, reqValid, expReq);
    if (expReq) chk("R5 reqLen", reqLen, reqQ.size());
  endtask

  task automatic loadResp(input logic [7:0] bytes[$], input bit unsol);
    foreach (bytes[i]) begin
      @(negedge clk);
      rspWe = 1'b1; rspAddr = AW'(i); rspByte = bytes[i];
    end
    @(negedge clk);
    rspWe = 1'b0; rspPost = 1'b1; rspLen = CW'(bytes.size()); rspUnsol = unsol;
    @(negedge clk);
    rspPost = 1'b0;
    rspQ = bytes; mAvail = 1; mSms = unsol;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rsp[$];
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, v); chk("R1 data", v, 8'h00);
    readReg(2'd1, v); chk("R1 status", v, 8'hC0);
    readReg(2'd2, v); chk("R1 flags", v, 8'h40);
    readReg(2'd3, v); chk("R2 offset3", v, 8'h00);

    // R4 R5 three-byte request
    cmd(8'h40, 8'h00, "R2 getstatus");
    cmd(8'h41, 8'h18, "R4 wrstart");
    cmd(8'h42, 8'h01, "R4 wrnext");
    cmd(8'h43, 8'h2C, "R5 wrend");
    for (int i = 0; i < 3; i++) begin
      reqRdAddr = AW'(i);
      #1 chk("R4 request byte", reqRdData, reqQ[i]);
    end

    // R6 R7 four-byte response, R3 ignored data write while busy
    rsp = {8'h1C, 8'h01, 8'h00, 8'h5A};
    loadResp(rsp, 1'b0);
    checkRegs("R7 rx ready");
    cmd(8'h44, 8'h00, "R6 rdstart R3 poke", 1'b1);
    cmd(8'h45, 8'h00, "R6 rdnext");
    cmd(8'h45, 8'h00, "R6 rdnext");
    cmd(8'h45, 8'h00, "R6 rdlast");
    chk("R6 final status", mStatus, 8'hC6);
    cmd(8'h45, 8'h00, "R8 rdnext past end");
    cmd(8'h46, 8'h00, "R8 rdend outside read");

    // R11 unsolicited message
    loadResp(rsp, 1'b1);
    checkRegs("R11 sms set");
    cmd(8'h44, 8'h00, "R11 rdstart");
    cmd(8'h46, 8'h00, "R11 rdend clears");

    // R10 no response
    cmd(8'h44, 8'h00, "R10 rdstart empty");

    // R8 illegal control
    cmd(8'h42, 8'h33, "R8 wrnext no start");
    cmd(8'h43, 8'h33, "R8 wrend no start");
    cmd(8'h47, 8'h00, "R8 code 7");
    cmd(8'h61, 8'h00, "R8 wrong stream");
    cmd(8'hC1, 8'h00, "R8 bit7 set");
    cmd(8'h51, 8'h77, "R2 bit4 ignored");
    cmd(8'h40, 8'h00, "R2 getstatus closes");

    // R9 overflow
    cmd(8'h41, 8'h00, "R9 start");
    for (int i = 1; i < MAXB; i++) cmd(8'h42, 8'(i), "R9 fill");
    readReg(2'd2, v); chk("R9 tx bit full", v[6], 1'b0);
    cmd(8'h43, 8'hEE, "R9 wrend overflow");
    chk("R9 error code", mData, 8'h05);
    reqRdAddr = AW'(MAXB - 1);
    #1 chk("R9 last kept byte", reqRdData, 8'(MAXB - 1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule